// File: doc/BRIEF.md
# Bit-Serial Distributed-Arithmetic FIR Filter

This block is a finite impulse response filter that uses no multipliers. It keeps the most recent `NTAPS` signed input samples in a shift register. To compute one output it steps through the bit positions of the samples, one bit position per clock, least significant bit first. In each step it gathers bit `b` of every stored sample into an address vector. Slices of that vector of `GRP_TAPS` bits each address small partial-sum tables. The table words are added together, weighted by `2^b` and accumulated. Because the samples are two's complement, the step for the sign bit subtracts its weighted sum instead of adding it.

The partial-sum tables are filled before filtering starts, through a plain write port. For group `g`, the word at address `A` must hold the sum of the coefficients `c[g*GRP_TAPS + j]` for every `j` where bit `j` of `A` is set. Working out these sums is the job of the surrounding logic.

A new sample is taken when the engine is idle or when it is in the last bit step of the current output. A stream can therefore arrive at one sample every `DW` clocks. The result appears on a full-precision output together with a one-cycle valid pulse.

Top module: `fir_da_top`

## Requirements
- R1: While `rst_n` is low and after its release, `out_valid` is 0, `out_data` is 0 and every stored sample is zero, so the first result after reset depends only on the first accepted sample.
- R2: A cycle with `tbl_we` high stores `tbl_wdata` at address `tbl_addr` of table `tbl_grp`. Address bit `j` of table `g` carries tap `g*GRP_TAPS + j`, and tap 0 is the newest sample.
- R3: Every result equals the exact sum over k of `c[k]*x[n-k]` for k = 0..NTAPS-1, with two's-complement samples and coefficients. It is given on `DW + CW + clog2(NTAPS)` bits and never overflows, including when every sample and coefficient is at its most negative value.
- R4: `out_valid` is high for exactly one cycle. That cycle begins `DW` clock edges after the edge that accepted the sample, and `out_valid` is low during the cycles in between.
- R5: A strobe on `in_valid` while the engine is idle is accepted at that clock edge and shifts the sample history by one position.
- R6: A sample offered during the last bit step of a computation is accepted at the same edge that completes the current result, which gives gap-free throughput of one sample every `DW` cycles.
- R7: A strobe on `in_valid` during any bit step of a running computation other than the last has no effect: neither the current result nor later results change.
- R8: `out_data` holds its value between `out_valid` pulses.
- R9: The sign-bit step subtracts its weighted table sum. A history holding only the most negative sample value gives `-2^(DW-1)` times the sum of the coefficients.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; asserts asynchronously, released synchronously |
| in_valid | input | 1 | Sample strobe |
| in_data | input | DW | Signed input sample |
| tbl_we | input | 1 | Table write enable |
| tbl_grp | input | max(1,clog2(NTAPS/GRP_TAPS)) | Table (tap group) select |
| tbl_addr | input | GRP_TAPS | Table word address |
| tbl_wdata | input | CW+clog2(GRP_TAPS) | Signed partial-sum word to store |
| out_valid | output | 1 | One-cycle result strobe |
| out_data | output | DW+CW+clog2(NTAPS) | Signed filter result |

## Verification
Two situations are hard to reach from the ports. The first is a sample that lands in exactly the last bit step, which must be accepted. The second is a strobe that lands in a middle bit step, which must be discarded. The stimulus counts clock edges from each acceptance, places the next sample on the `DW`-th edge to drive gap-free streams, and puts a junk strobe partway through a computation. The expected results come from a sample history kept in the bench, so a junk sample that was wrongly taken shows up in the current result and in every result after it. Coefficient sets built for the purpose check the table-to-tap mapping (a single non-zero tap) and the worst-case sign-bit subtraction (every value at its most negative).

// File: rtl/fir_da_pkg.sv
package fir_da_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } fir_state_e;

  // index width that never collapses to zero bits
  function automatic int unsigned idx_w(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/fir_da_ctrl.sv
module fir_da_ctrl
  import fir_da_pkg::*;
#(
  parameter int unsigned DW = 8,
  parameter int unsigned BW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          accept,
  output logic          run,
  output logic          first_bit,
  output logic          last_bit,
  output logic [BW-1:0] bit_idx
);

  fir_state_e    state_q, state_d;
  logic [BW-1:0] bit_q, bit_d;

  assign run       = (state_q == ST_RUN);
  assign first_bit = run && (bit_q == '0);
  assign last_bit  = run && (bit_q == BW'(DW - 1));
  assign accept    = in_valid && (!run || last_bit);
  assign bit_idx   = bit_q;

  always_comb begin
    state_d = state_q;
    bit_d   = bit_q;
    if (accept) begin
      state_d = ST_RUN;
      bit_d   = '0;
    end else if (last_bit) begin
      state_d = ST_IDLE;
      bit_d   = '0;
    end else if (run) begin
      bit_d   = bit_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      bit_q   <= '0;
    end else begin
      state_q <= state_d;
      bit_q   <= bit_d;
    end
  end

endmodule

// File: rtl/fir_da_delay.sv
module fir_da_delay #(
  parameter int unsigned NTAPS = 8,
  parameter int unsigned DW    = 8,
  parameter int unsigned BW    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_en,
  input  logic [DW-1:0]    din,
  input  logic [BW-1:0]    bit_sel,
  output logic [NTAPS-1:0] slice,
  output logic [DW-1:0]    newest
);

  logic [NTAPS-1:0][DW-1:0] tap_q, tap_d;

  always_comb begin
    tap_d    = tap_q;
    tap_d[0] = din;
    for (int k = 1; k < NTAPS; k++) begin
      tap_d[k] = tap_q[k-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tap_q <= '0;
    end else if (shift_en) begin
      tap_q <= tap_d;
    end
  end

  for (genvar k = 0; k < NTAPS; k++) begin : g_slice
    assign slice[k] = tap_q[k][bit_sel];
  end

  assign newest = tap_q[0];

endmodule

// File: rtl/fir_da_table.sv
module fir_da_table #(
  parameter int unsigned Q  = 4,
  parameter int unsigned TW = 10
) (
  input  logic          clk,
  input  logic          we,
  input  logic [Q-1:0]  waddr,
  input  logic [TW-1:0] wdata,
  input  logic [Q-1:0]  raddr,
  output logic [TW-1:0] rdata
);

  localparam int unsigned DEPTH = 1 << Q;

  // storage array: filled before use, so it has no reset
  logic [TW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem_q[waddr] <= wdata;
    end
  end

  assign rdata = mem_q[raddr];

endmodule

// File: rtl/fir_da_accum.sv
module fir_da_accum #(
  parameter int unsigned P  = 2,
  parameter int unsigned TW = 10,
  parameter int unsigned OW = 19,
  parameter int unsigned BW = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                run,
  input  logic                first_bit,
  input  logic                last_bit,
  input  logic [BW-1:0]       bit_idx,
  input  logic [P-1:0][TW-1:0] grp_word,
  output logic                out_valid,
  output logic [OW-1:0]       out_data
);

  logic signed [OW-1:0] lut_sum, term, base, acc_d;
  logic signed [OW-1:0] acc_q, res_q;
  logic                 vld_q;

  always_comb begin
    lut_sum = '0;
    for (int g = 0; g < P; g++) begin
      lut_sum = lut_sum + $signed({{(OW-TW){grp_word[g][TW-1]}}, grp_word[g]});
    end
    term  = lut_sum <<< bit_idx;
    base  = first_bit ? '0 : acc_q;
    acc_d = last_bit ? (base - term) : (base + term);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else if (run) begin
      acc_q <= acc_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
    end else if (last_bit) begin
      res_q <= acc_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
    end else begin
      vld_q <= last_bit;
    end
  end

  assign out_valid = vld_q;
  assign out_data  = res_q;

endmodule

// File: rtl/fir_da_top.sv
module fir_da_top
  import fir_da_pkg::*;
#(
  parameter int unsigned NTAPS    = 8,
  parameter int unsigned GRP_TAPS = 4,
  parameter int unsigned DW       = 8,
  parameter int unsigned CW       = 8,
  localparam int unsigned P       = NTAPS / GRP_TAPS,
  localparam int unsigned GW      = idx_w(P),
  localparam int unsigned BW      = idx_w(DW),
  localparam int unsigned TW      = CW + $clog2(GRP_TAPS),
  localparam int unsigned OW      = DW + CW + $clog2(NTAPS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [DW-1:0]       in_data,
  input  logic                tbl_we,
  input  logic [GW-1:0]       tbl_grp,
  input  logic [GRP_TAPS-1:0] tbl_addr,
  input  logic [TW-1:0]       tbl_wdata,
  output logic                out_valid,
  output logic [OW-1:0]       out_data
);

  logic                 accept, run, first_bit, last_bit;
  logic [BW-1:0]        bit_idx;
  logic [NTAPS-1:0]     slice;
  logic [DW-1:0]        newest_tap;
  logic [P-1:0][TW-1:0] grp_word;

  fir_da_ctrl #(.DW(DW), .BW(BW)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .accept    (accept),
    .run       (run),
    .first_bit (first_bit),
    .last_bit  (last_bit),
    .bit_idx   (bit_idx)
  );

  fir_da_delay #(.NTAPS(NTAPS), .DW(DW), .BW(BW)) u_delay (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (accept),
    .din      (in_data),
    .bit_sel  (bit_idx),
    .slice    (slice),
    .newest   (newest_tap)
  );

  for (genvar g = 0; g < P; g++) begin : g_tbl
    logic we_g;
    assign we_g = tbl_we && (tbl_grp == GW'(g));
    fir_da_table #(.Q(GRP_TAPS), .TW(TW)) u_tbl (
      .clk   (clk),
      .we    (we_g),
      .waddr (tbl_addr),
      .wdata (tbl_wdata),
      .raddr (slice[g*GRP_TAPS +: GRP_TAPS]),
      .rdata (grp_word[g])
    );
  end

  fir_da_accum #(.P(P), .TW(TW), .OW(OW), .BW(BW)) u_acc (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .first_bit (first_bit),
    .last_bit  (last_bit),
    .bit_idx   (bit_idx),
    .grp_word  (grp_word),
    .out_valid (out_valid),
    .out_data  (out_data)
  );

endmodule

// File: rtl/fir_da_chk.sv
module fir_da_chk #(
  parameter int unsigned DW = 8,
  parameter int unsigned OW = 19,
  localparam int unsigned CNW = $clog2(DW + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          accept,
  input logic          run,
  input logic          last_bit,
  input logic [DW-1:0] newest_tap,
  input logic          out_valid,
  input logic [OW-1:0] out_data
);

  // edges elapsed since the last accepted sample (0 = none pending)
  logic [CNW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (accept) begin
      cnt_q <= CNW'(1);
    end else if (cnt_q == CNW'(DW)) begin
      cnt_q <= '0;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  a_r4_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CNW'(DW)) |=> out_valid);

  a_r4_no_early: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(cnt_q == CNW'(DW)));

  a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (DW > 1 && out_valid) |=> !out_valid);

  a_r7_busy_ignore: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !last_bit) |=> $stable(newest_tap));

  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_data));

endmodule

bind fir_da_top fir_da_chk #(.DW(DW), .OW(OW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .accept     (accept),
  .run        (run),
  .last_bit   (last_bit),
  .newest_tap (newest_tap),
  .out_valid  (out_valid),
  .out_data   (out_data)
);

// File: tb/test_fir_da_top.sv
`timescale 1ns/1ps
module test_fir_da_top;

  localparam int NTAPS = 8;
  localparam int Q     = 4;
  localparam int DW    = 8;
  localparam int CW    = 8;
  localparam int P     = NTAPS / Q;
  localparam int GW    = 1;
  localparam int TW    = CW + $clog2(Q);
  localparam int OW    = DW + CW + $clog2(NTAPS);

  logic          clk = 1'b0;
  logic          rst_n;
  logic          in_valid;
  logic [DW-1:0] in_data;
  logic          tbl_we;
  logic [GW-1:0] tbl_grp;
  logic [Q-1:0]  tbl_addr;
  logic [TW-1:0] tbl_wdata;
  logic          out_valid;
  logic [OW-1:0] out_data;

  always #4 clk = ~clk;

  fir_da_top #(.NTAPS(NTAPS), .GRP_TAPS(Q), .DW(DW), .CW(CW)) i_fir_da_top (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .tbl_we(tbl_we), .tbl_grp(tbl_grp), .tbl_addr(tbl_addr),
    .tbl_wdata(tbl_wdata), .out_valid(out_valid), .out_data(out_data)
  );

  int     n_chk = 0;
  int     n_err = 0;
  longint coef [NTAPS];
  longint hist [NTAPS];
  longint seq  [64];

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint sx(input logic [DW-1:0] v);
    return longint'($signed(v));
  endfunction

  function automatic longint out_s();
    return longint'($signed(out_data));
  endfunction

  function automatic longint ref_y();
    longint s = 0;
    for (int k = 0; k < NTAPS; k++) s += coef[k] * hist[k];
    return s;
  endfunction

  task automatic push_model(input longint x);
    for (int k = NTAPS - 1; k > 0; k--) hist[k] = hist[k-1];
    hist[0] = x;
  endtask

  // R2: table g, address a holds sum of c[g*Q+j] over set bits j of a
  task automatic load_tables();
    for (int g = 0; g < P; g++) begin
      for (int a = 0; a < (1 << Q); a++) begin
        longint s = 0;
        for (int j = 0; j < Q; j++) if (a[j]) s += coef[g*Q + j];
        tbl_we    = 1'b1;
        tbl_grp   = GW'(g);
        tbl_addr  = Q'(a);
        tbl_wdata = TW'(s);
        @(negedge clk);
      end
    end
    tbl_we = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    in_valid = 1'b0;
    for (int k = 0; k < NTAPS; k++) hist[k] = 0;
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R1 valid in reset", longint'(out_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R1 valid after reset", longint'(out_valid), 0);
    chk(out_s() == 0, "R1 data after reset", out_s(), 0);
  endtask

  // single sample from idle, optional junk strobe mid-computation
  task automatic send_one(input longint x, input bit junk, input string req);
    in_valid = 1'b1;
    in_data  = DW'(x);
    @(negedge clk);
    in_valid = 1'b0;
    push_model(x);
    for (int i = 1; i < DW; i++) begin
      if (junk && i == 2) begin
        in_valid = 1'b1;
        in_data  = DW'(8'h55 ^ x);
      end
      @(negedge clk);
      in_valid = 1'b0;
      if (i == DW - 1)
        chk(out_valid == 1'b0, "R4 no early valid", longint'(out_valid), 0);
    end
    @(negedge clk);
    chk(out_valid == 1'b1, "R4 valid after DW edges", longint'(out_valid), 1);
    chk(out_s() == ref_y(), req, out_s(), ref_y());
    begin
      longint held = out_s();
      @(negedge clk);
      chk(out_valid == 1'b0, "R4 one-cycle pulse", longint'(out_valid), 0);
      chk(out_s() == held, "R8 hold", out_s(), held);
    end
  endtask

  // R6: gap-free stream, next sample in each final bit cycle
  task automatic stream(input int n, input string req);
    in_valid = 1'b1;
    in_data  = DW'(seq[0]);
    @(negedge clk);
    in_valid = 1'b0;
    push_model(seq[0]);
    for (int s = 0; s < n; s++) begin
      repeat (DW - 1) @(negedge clk);
      if (s < n - 1) begin
        in_valid = 1'b1;
        in_data  = DW'(seq[s+1]);
      end
      @(negedge clk);
      in_valid = 1'b0;
      chk(out_valid == 1'b1, "R6 back-to-back valid", longint'(out_valid), 1);
      chk(out_s() == ref_y(), req, out_s(), ref_y());
      if (s < n - 1) push_model(seq[s+1]);
    end
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'h1F2E3D4C));
    rst_n = 1'b0; in_valid = 1'b0; in_data = '0;
    tbl_we = 1'b0; tbl_grp = '0; tbl_addr = '0; tbl_wdata = '0;
    @(negedge clk);
    do_reset();

    // R2: single non-zero tap (tap 5, second table) exposes the mapping
    for (int k = 0; k < NTAPS; k++) coef[k] = (k == 5) ? 3 : 0;
    load_tables();
    for (int i = 0; i < 8; i++) seq[i] = i * 7 - 20;
    stream(8, "R2 tap mapping");

    // R1: after reset the first result uses only the first sample
    for (int k = 0; k < NTAPS; k++) coef[k] = sx(DW'($urandom));
    load_tables();
    do_reset();
    send_one(-77, 1'b0, "R1 first result after reset");

    // R5 / R7: idle acceptance, junk strobe mid-run
    send_one(45, 1'b1, "R7 junk ignored (current)");
    send_one(-3, 1'b0, "R7 junk ignored (next) R5");

    // R3: random streams with R6 back-to-back
    for (int r = 0; r < 4; r++) begin
      for (int k = 0; k < NTAPS; k++) coef[k] = sx(DW'($urandom));
      load_tables();
      for (int i = 0; i < 20; i++) seq[i] = sx(DW'($urandom));
      stream(20, "R3 random stream");
      send_one(sx(DW'($urandom)), 1'b1, "R3 R7 random with junk");
    end

    // R9 / R3: all values most negative, worst-case magnitude
    for (int k = 0; k < NTAPS; k++) coef[k] = -(1 << (CW - 1));
    load_tables();
    for (int i = 0; i < NTAPS; i++) seq[i] = -(1 << (DW - 1));
    stream(NTAPS, "R9 sign-bit subtract / R3 no overflow");

    // R9: only most negative samples, mixed coefficients
    for (int k = 0; k < NTAPS; k++) coef[k] = k - 3;
    load_tables();
    for (int i = 0; i < NTAPS; i++) seq[i] = -(1 << (DW - 1));
    stream(NTAPS, "R9 mixed coefficients");

    // R3: largest positive inputs
    for (int i = 0; i < NTAPS; i++) seq[i] = (1 << (DW - 1)) - 1;
    stream(NTAPS, "R3 max positive");

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule